// File: doc/BRIEF.md
# Accumulator Clamp Readout

This block turns a wide per-lane accumulator into 16-bit lane results. Each of the eight lanes presents a 48-bit value as three 16-bit slices: a top slice (bits 47:32), a middle slice (bits 31:16) and a bottom slice (bits 15:0). A 2-bit mode input picks one of four conversions, and every lane uses the same conversion in the same cycle.

The conversions are: a plain copy of the bottom slice; a signed saturation of bits 47:16 to sixteen bits; a hybrid unsigned saturation built on that signed result; and a saturation-aware bottom readout. The saturation-aware readout returns the bottom slice unless the signed saturation changed the middle slice, in which case it returns the saturated value with its top bit flipped. Both non-standard conversions have deliberate boundary quirks that are kept exactly.

The result is registered. A request with `in_valid` high produces its lane results one clock later, with `out_valid` high for that cycle. While `in_valid` is low the output register holds its last value.

Top module: `acc_clamp_readout`

## Requirements
- R1: `out_valid` equals the value that `in_valid` had on the previous rising clock edge.
- R2: When `in_valid` is low on a rising edge, `out_data` keeps its previous value.
- R3: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R4: Mode 0 (`mode` = 2'b00) returns each lane's bottom slice unchanged.
- R5: Mode 1 (`mode` = 2'b01) returns the middle slice unchanged when bits 47:16, read as a signed 32-bit number, lie within -32768..+32767.
- R6: Mode 1 returns 0x8000 when bits 47:16 are below -32768 (top slice below -1, or top slice equal to -1 with middle bit 15 clear) and 0x7FFF when they are above +32767 (top slice above 0, or top slice 0 with middle bit 15 set).
- R7: Mode 2 (`mode` = 2'b10) returns 0x0000 whenever the mode 1 result is negative.
- R8: Mode 2 returns 0xFFFF when the mode 1 result is signed-greater than the raw middle slice, and otherwise the non-negative mode 1 result; so a lane with top slice above 0 and middle slice 0x7FFF gives 0x7FFF.
- R9: Mode 3 (`mode` = 2'b11) returns the bottom slice when the mode 1 result equals the raw middle slice, and otherwise the mode 1 result XOR 0x8000 (0xFFFF on positive saturation, 0x0000 on negative saturation).
- R10: In mode 3, a lane that saturates but whose saturated value equals the raw middle slice (for example top slice 0xFFFE with middle 0x8000) returns its bottom slice.
- R11: Lane i uses bits 16i+15..16i of each slice bus and of `out_data`; lanes do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the output register |
| mode | input | 2 | Conversion select (0 bottom, 1 signed, 2 unsigned hybrid, 3 saturation-aware bottom) |
| acc_hi | input | 128 | Top slices of eight lanes, lane i at bits 16i+15..16i |
| acc_mid | input | 128 | Middle slices of eight lanes |
| acc_lo | input | 128 | Bottom slices of eight lanes |
| out_valid | output | 1 | High one cycle after an accepted request |
| out_data | output | 128 | Registered 16-bit results of eight lanes |

## Verification
Every cycle, the assertions check the one-cycle valid timing, the hold of the output while idle, and lane 0 against the simplest slice patterns: the bottom copy, in-range pass-through, positive saturation, the zero floor of the unsigned hybrid and negative saturation in the aware mode. The hybrid's 0xFFFF decision, the mode 3 case where saturation leaves the middle slice equal and the bottom slice comes out, and independence across all eight lanes appear only in the bench's directed corner vectors and its long mixed-mode sweep compared against the reference model.

// File: rtl/acc_clamp_pkg.sv
package acc_clamp_pkg;
  localparam int unsigned LANES_DEF = 8;
  localparam int unsigned SLICE_W_DEF = 16;

  typedef enum logic [1:0] {
    RD_LOW    = 2'd0,
    RD_SMID   = 2'd1,
    RD_UMID   = 2'd2,
    RD_LOWSAT = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/acc_clamp_sat.sv
// Signed saturation of {top, mid} to one slice width, with change flag.
module acc_clamp_sat #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] top_s,
  input  logic [W-1:0] mid_s,
  output logic [W-1:0] sat_val,
  output logic         sat_changed
);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic top_neg, top_ones, top_zero, under, over;

  always_comb begin
    top_neg  = top_s[W-1];
    top_ones = &top_s;
    top_zero = ~|top_s;
    // below -1, or exactly -1 with a clear mid sign bit
    under    = top_neg & ~(top_ones & mid_s[W-1]);
    // above 0, or exactly 0 with a set mid sign bit
    over     = ~top_neg & ~(top_zero & ~mid_s[W-1]);
    if (under)     sat_val = SMIN;
    else if (over) sat_val = SMAX;
    else           sat_val = mid_s;
    sat_changed = (sat_val != mid_s);
  end
endmodule

// File: rtl/acc_clamp_lane.sv
// One lane: mode selection over the saturated middle value.
module acc_clamp_lane
  import acc_clamp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  rd_mode_e     mode_i,
  input  logic [W-1:0] top_s,
  input  logic [W-1:0] mid_s,
  input  logic [W-1:0] low_s,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sat_val;
  logic         sat_changed;
  logic [W-1:0] floor_val;
  logic         sat_gt_raw;
  logic [W-1:0] umid_val;
  logic [W-1:0] lowsat_val;

  acc_clamp_sat #(.W(W)) u_sat (
    .top_s      (top_s),
    .mid_s      (mid_s),
    .sat_val    (sat_val),
    .sat_changed(sat_changed)
  );

  always_comb begin
    floor_val  = sat_val[W-1] ? '0 : sat_val;
    sat_gt_raw = $signed(sat_val) > $signed(mid_s);
    umid_val   = sat_gt_raw ? '1 : floor_val;
    lowsat_val = sat_changed ? (sat_val ^ SIGN_BIT) : low_s;
    unique case (mode_i)
      RD_LOW:    res_o = low_s;
      RD_SMID:   res_o = sat_val;
      RD_UMID:   res_o = umid_val;
      RD_LOWSAT: res_o = lowsat_val;
      default:   res_o = low_s;
    endcase
  end
endmodule

// File: rtl/acc_clamp_readout.sv
module acc_clamp_readout
  import acc_clamp_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned SLICE_W = SLICE_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               mode,
  input  logic [LANES*SLICE_W-1:0] acc_hi,
  input  logic [LANES*SLICE_W-1:0] acc_mid,
  input  logic [LANES*SLICE_W-1:0] acc_lo,
  output logic                     out_valid,
  output logic [LANES*SLICE_W-1:0] out_data
);
  localparam int unsigned BUS_W = LANES * SLICE_W;

  rd_mode_e         mode_e;
  logic [BUS_W-1:0] lane_res;
  logic [BUS_W-1:0] data_nxt;
  logic             valid_nxt;
  logic             data_en;

  assign mode_e = rd_mode_e'(mode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    acc_clamp_lane #(.W(SLICE_W)) u_lane (
      .mode_i(mode_e),
      .top_s (acc_hi [g*SLICE_W +: SLICE_W]),
      .mid_s (acc_mid[g*SLICE_W +: SLICE_W]),
      .low_s (acc_lo [g*SLICE_W +: SLICE_W]),
      .res_o (lane_res[g*SLICE_W +: SLICE_W])
    );
  end

  always_comb begin
    data_en   = in_valid;
    valid_nxt = in_valid;
    data_nxt  = data_en ? lane_res : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_nxt;
      if (data_en) out_data <= data_nxt;
    end
  end
endmodule

// File: rtl/acc_clamp_readout_chk.sv
module acc_clamp_readout_chk #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned SLICE_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [1:0]               mode,
  input logic [LANES*SLICE_W-1:0] acc_hi,
  input logic [LANES*SLICE_W-1:0] acc_mid,
  input logic [LANES*SLICE_W-1:0] acc_lo,
  input logic                     out_valid,
  input logic [LANES*SLICE_W-1:0] out_data
);
  logic [SLICE_W-1:0] h0, m0, l0, o0;
  assign h0 = acc_hi[SLICE_W-1:0];
  assign m0 = acc_mid[SLICE_W-1:0];
  assign l0 = acc_lo[SLICE_W-1:0];
  assign o0 = out_data[SLICE_W-1:0];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid))); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data)); // R2

  AST_RAW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(mode) == 2'd0) |-> (o0 == $past(l0))); // R4

  AST_SMID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(mode) == 2'd1 && $past(h0) == '0
     && !$past(m0[SLICE_W-1])) |-> (o0 == $past(m0))); // R5

  AST_SMID_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(mode) == 2'd1 && !$past(h0[SLICE_W-1])
     && $past(h0) != '0) |-> (o0 == {1'b0, {(SLICE_W-1){1'b1}}})); // R6

  AST_UMID_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(mode) == 2'd2 && $past(h0[SLICE_W-1]))
     |-> (o0 == '0)); // R7

  AST_LOWSAT_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(mode) == 2'd3 && $past(h0[SLICE_W-1])
     && !(&$past(h0)) && $past(m0) != {1'b1, {(SLICE_W-1){1'b0}}}) |-> (o0 == '0)); // R9
endmodule

bind acc_clamp_readout acc_clamp_readout_chk #(.LANES(LANES), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/acc_clamp_readout_bench.sv
`timescale 1ns/1ps
module acc_clamp_readout_bench;
  localparam int LANES = 8;
  localparam int W = 16;
  localparam int BW = LANES * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode;
  logic [BW-1:0] acc_hi, acc_mid, acc_lo;
  logic          out_valid;
  logic [BW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic          exp_valid;
  logic [BW-1:0] exp_data;

  always #2.5 clk = ~clk;

  acc_clamp_readout u_acc_clamp_readout (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .acc_hi(acc_hi), .acc_mid(acc_mid), .acc_lo(acc_lo),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Behavioural reference from the requirements (integer arithmetic).
  function automatic logic [15:0] ref_lane(input logic [1:0] m, input logic [15:0] h,
                                           input logic [15:0] md, input logic [15:0] l);
    int v, raw, s, r;
    v   = $signed({h, md});
    raw = $signed(md);
    if (v < -32768)     s = -32768;
    else if (v > 32767) s = 32767;
    else                s = v;
    case (m)
      2'd0: r = l;
      2'd1: r = s;
      2'd2: begin
        r = (s < 0) ? 0 : s;
        if (s > raw) r = 16'hFFFF;
      end
      default: r = (s != raw) ? ((s & 16'hFFFF) ^ 16'h8000) : l;
    endcase
    return r[15:0];
  endfunction

  function automatic logic [BW-1:0] ref_bus(input logic [1:0] m);
    logic [BW-1:0] b;
    for (int i = 0; i < LANES; i++)
      b[i*W +: W] = ref_lane(m, acc_hi[i*W +: W], acc_mid[i*W +: W], acc_lo[i*W +: W]);
    return b;
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] want,
                       input logic gv, input logic wv);
    checks++;
    if (got !== want || gv !== wv) begin
      failures++;
      $display("FAIL %s valid=%0b/%0b data=%h expected=%h", tag, gv, wv, got, want);
    end
  endtask

  // One clock: inputs driven at negedge, compared at the following negedge.
  task automatic cycle(input logic v, input logic [1:0] m, input string tag);
    in_valid = v;
    mode = m;
    if (v) exp_data = ref_bus(m);
    exp_valid = v;
    @(posedge clk);
    @(negedge clk);
    check(tag, out_data, exp_data, out_valid, exp_valid);
  endtask

  task automatic check_lane(input string tag, input int lane, input logic [15:0] want);
    checks++;
    if (out_data[lane*W +: W] !== want) begin
      failures++;
      $display("FAIL %s lane %0d actual=%h expected=%h", tag, lane, out_data[lane*W +: W], want);
    end
  endtask

  task automatic load_corners();
    logic [15:0] hv [8] = '{16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF,
                            16'h0001, 16'hFFFE, 16'h7FFF, 16'h8000};
    logic [15:0] mv [8] = '{16'h1234, 16'h8000, 16'h8000, 16'h7FFF,
                            16'h7FFF, 16'h8000, 16'hFFFF, 16'h0000};
    for (int i = 0; i < LANES; i++) begin
      acc_hi[i*W +: W]  = hv[i];
      acc_mid[i*W +: W] = mv[i];
      acc_lo[i*W +: W]  = 16'hA500 + 16'(i);
    end
  endtask

  function automatic logic [15:0] pick_hi(input int unsigned r);
    case (r % 5)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0001;
      3: return 16'hFFFE;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'd0;
    acc_hi = '0; acc_mid = '0; acc_lo = '0;
    exp_valid = 1'b0; exp_data = '0;
    repeat (3) @(negedge clk);
    check("R3 reset state", out_data, '0, out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    load_corners();
    cycle(1'b1, 2'd0, "R4 raw low corners R11");
    cycle(1'b1, 2'd1, "R5/R6 signed corners R11");
    check_lane("R5 min in range", 2, 16'h8000);
    check_lane("R6 over via sign", 1, 16'h7FFF);
    check_lane("R6 under top -2", 5, 16'h8000);
    cycle(1'b1, 2'd2, "R7/R8 unsigned corners R11");
    check_lane("R8 top>0 mid 7FFF", 4, 16'h7FFF);
    check_lane("R8 forced FFFF", 1, 16'hFFFF);
    check_lane("R7 negative floor", 7, 16'h0000);
    cycle(1'b1, 2'd3, "R9/R10 aware low corners R11");
    check_lane("R9 positive sat", 1, 16'hFFFF);
    check_lane("R9 in range low", 0, 16'hA500);
    check_lane("R10 sat equals mid", 5, 16'hA505);
    check_lane("R10 over equals mid", 4, 16'hA504);

    acc_hi = '1; acc_mid = '0; acc_lo = '1;
    cycle(1'b0, 2'd0, "R1/R2 idle hold");
    cycle(1'b0, 2'd2, "R1/R2 idle hold");

    for (int n = 0; n < 2000; n++) begin
      for (int i = 0; i < LANES; i++) begin
        acc_hi[i*W +: W]  = pick_hi($urandom);
        acc_mid[i*W +: W] = ($urandom % 4 == 0) ? {$urandom % 2 == 0, 15'h7FFF ^ 15'($urandom % 2 * 16'h7FFF)} : 16'($urandom);
        acc_lo[i*W +: W]  = 16'($urandom);
      end
      cycle(($urandom % 4) != 0, 2'($urandom), "R1/R2/R4-R11 sweep");
    end

    rst_n = 1'b0;
    #1;
    check("R3 reset mid-run", out_data, '0, out_valid, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule